// File: doc/BRIEF.md
# Multi-Mode Decimating FIR Stage

This block is the second filtering stage of a digital down-conversion chain. It receives complex baseband samples (an I word and a Q word sharing one valid strobe) at the rate produced by an earlier high-ratio decimator. It runs them through a programmable FIR filter and emits full-precision results at a reduced rate. A two-bit mode input selects the output mode. Quadrature mode filters both paths and keeps one result in four. Real mode keeps only the I path and one result in two. Filter-only mode keeps only the I path and one result in four.

Each path keeps a circular history of its last TAPS samples in a small RAM. Taps are held in a second RAM that a plain address/data write port fills while no samples arrive. On each decimation slot, a sequencer walks one tap per clock through a multiply-accumulate loop. The loop runs over the sample history and the coefficient store. The sum is kept with enough guard bits to hold every partial sum exactly and is saturated once, into a 38-bit output word.

Top module: `deci_fir`

## Requirements
- R1: A cycle with `coef_we` high stores the 22-bit two's-complement `coef_data` as tap `coef_addr` (0 to TAPS-1). Tap k weights the sample that is k inputs older than the newest one. Reset does not clear the taps.
- R2: Each result equals the sum over k of tap[k] times sample[n-k], where n is the input that closes the decimation slot. Samples from before the last reset count as zero.
- R3: Mode 0 (quadrature) produces a result on both paths for every 4th accepted input after reset. `out_i_valid` and `out_q_valid` are asserted in the same cycle.
- R4: Mode 1 (real) produces an I result for every 2nd accepted input. `out_q` stays zero and `out_q_valid` never asserts.
- R5: Modes 2 and 3 (filter-only) produce an I result for every 4th accepted input. `out_q` stays zero and `out_q_valid` never asserts.
- R6: A sum above 2^37-1 is output as 2^37-1. A sum below -2^37 is output as -2^37.
- R7: Synchronous reset drives both outputs and both strobes to zero. It also empties the sample history and restarts the decimation count.
- R8: Each valid strobe is a one-cycle pulse that appears TAPS+1 clock edges after the edge that accepts the slot-closing input. Consecutive inputs must be spaced at least TAPS+2 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | 0 quadrature, 1 real, 2/3 filter-only; changed only under reset |
| coef_we | input | 1 | Tap write enable |
| coef_addr | input | $clog2(TAPS) | Tap index to write |
| coef_data | input | CW | Signed tap value |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | DW | Signed I sample |
| in_q | input | DW | Signed Q sample |
| out_i | output | OW | Saturated I result |
| out_i_valid | output | 1 | I result strobe |
| out_q | output | OW | Saturated Q result |
| out_q_valid | output | 1 | Q result strobe |

## Verification
The bench builds the block with TAPS set to 6 and leaves the 16-bit samples, 22-bit taps and 38-bit results at their default widths. Six taps is not a power of two, so the history pointer wraps through its non-binary modulo path within a few samples. The test also keeps each slot short enough for many slots per mode. With six full-scale products the sum can still exceed 2^37, so both saturation limits can be reached with real data. A mid-slot reset shows that the zero-filled history and the restarted phase count take effect.

// File: rtl/deci_fir_pkg.sv
package deci_fir_pkg;
  typedef enum logic [1:0] {
    MODE_QUAD = 2'd0,
    MODE_REAL = 2'd1,
    MODE_FILT = 2'd2,
    MODE_FILT_ALT = 2'd3
  } fir_mode_e;
endpackage

// File: rtl/dfir_ram.sv
module dfir_ram #(
  parameter int W     = 16,
  parameter int DEPTH = 32,
  parameter int AW    = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/dfir_seq.sv
module dfir_seq #(
  parameter int TAPS = 32,
  parameter int AW   = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          dec_four,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic [AW-1:0] tap_addr,
  output logic          rd_en,
  output logic          acc_en,
  output logic          acc_first,
  output logic          acc_last,
  output logic          acc_keep
);
  localparam logic [AW-1:0] LAST_TAP = AW'(TAPS - 1);
  localparam logic [AW-1:0] TAPS_A   = AW'(TAPS);
  localparam logic [AW:0]   FULL     = (AW+1)'(TAPS);

  logic [1:0]    phase, phase_end;
  logic [AW-1:0] wr_ptr, newest, tap;
  logic [AW:0]   fill, fill_nx, fill_snap;
  logic          running;

  assign phase_end = dec_four ? 2'd3 : 2'd1;
  assign fill_nx   = (fill == FULL) ? fill : fill + 1'b1;
  assign wr_addr   = wr_ptr;
  assign tap_addr  = tap;
  assign rd_en     = running;
  assign rd_addr   = (newest >= tap) ? (newest - tap) : (newest + TAPS_A - tap);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= '0;
      wr_ptr    <= '0;
      newest    <= '0;
      fill      <= '0;
      fill_snap <= '0;
      tap       <= '0;
      running   <= 1'b0;
      acc_en    <= 1'b0;
      acc_first <= 1'b0;
      acc_last  <= 1'b0;
      acc_keep  <= 1'b0;
    end else begin
      acc_en    <= running;
      acc_first <= running && (tap == '0);
      acc_last  <= running && (tap == LAST_TAP);
      acc_keep  <= running && ({1'b0, tap} < fill_snap);
      if (running) begin
        tap <= tap + 1'b1;
        if (tap == LAST_TAP) running <= 1'b0;
      end
      if (in_valid) begin
        wr_ptr <= (wr_ptr == LAST_TAP) ? '0 : wr_ptr + 1'b1;
        newest <= wr_ptr;
        fill   <= fill_nx;
        phase  <= (phase == phase_end) ? 2'd0 : phase + 2'd1;
        if (phase == phase_end) begin
          running   <= 1'b1;
          tap       <= '0;
          fill_snap <= fill_nx;
        end
      end
    end
  end

  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> !(running || acc_en)); // R8
  AST_LOOP_STARTS_AT_TAP0: assert property (@(posedge clk) disable iff (rst)
    $rose(acc_en) |-> acc_first); // R2
endmodule

// File: rtl/dfir_mac.sv
module dfir_mac #(
  parameter int DW = 16,
  parameter int CW = 22,
  parameter int OW = 38,
  parameter int GW = 44
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en_path,
  input  logic                 acc_en,
  input  logic                 acc_first,
  input  logic                 acc_last,
  input  logic                 acc_keep,
  input  logic signed [DW-1:0] sample,
  input  logic signed [CW-1:0] coef,
  output logic signed [OW-1:0] out_data,
  output logic                 out_valid
);
  localparam int PW = DW + CW;
  localparam logic signed [GW-1:0] MAXV = {{(GW-OW+1){1'b0}}, {(OW-1){1'b1}}};
  localparam logic signed [GW-1:0] MINV = {{(GW-OW+1){1'b1}}, {(OW-1){1'b0}}};

  logic signed [PW-1:0] prod;
  logic signed [GW-1:0] acc, term, sum;
  logic signed [OW-1:0] sat;

  assign prod = sample * coef;
  assign term = acc_keep ? {{(GW-PW){prod[PW-1]}}, prod} : '0;
  assign sum  = (acc_first ? '0 : acc) + term;

  always_comb begin
    if (sum > MAXV)      sat = MAXV[OW-1:0];
    else if (sum < MINV) sat = MINV[OW-1:0];
    else                 sat = sum[OW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || !en_path) begin
      acc       <= '0;
      out_data  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (acc_en) begin
        acc <= sum;
        if (acc_last) begin
          out_data  <= sat;
          out_valid <= 1'b1;
        end
      end
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid); // R8
endmodule

// File: rtl/deci_fir.sv
module deci_fir
  import deci_fir_pkg::*;
#(
  parameter int DW   = 16,
  parameter int CW   = 22,
  parameter int OW   = 38,
  parameter int TAPS = 32,
  localparam int AW  = (TAPS > 1) ? $clog2(TAPS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    mode,
  input  logic          coef_we,
  input  logic [AW-1:0] coef_addr,
  input  logic [CW-1:0] coef_data,
  input  logic          in_valid,
  input  logic [DW-1:0] in_i,
  input  logic [DW-1:0] in_q,
  output logic [OW-1:0] out_i,
  output logic          out_i_valid,
  output logic [OW-1:0] out_q,
  output logic          out_q_valid
);
  localparam int GW = DW + CW + AW + 1;

  fir_mode_e     mode_e;
  logic          dec_four, q_en;
  logic [AW-1:0] wr_addr, rd_addr, tap_addr;
  logic          rd_en, acc_en, acc_first, acc_last, acc_keep;
  logic [CW-1:0] coef_rd;
  logic [OW-1:0] path_out [2];
  logic          path_vld [2];

  assign mode_e   = fir_mode_e'(mode);
  assign dec_four = (mode_e != MODE_REAL);
  assign q_en     = (mode_e == MODE_QUAD);

  dfir_seq #(.TAPS(TAPS), .AW(AW)) u_seq (
    .clk(clk), .rst(rst), .in_valid(in_valid), .dec_four(dec_four),
    .wr_addr(wr_addr), .rd_addr(rd_addr), .tap_addr(tap_addr), .rd_en(rd_en),
    .acc_en(acc_en), .acc_first(acc_first), .acc_last(acc_last), .acc_keep(acc_keep)
  );

  dfir_ram #(.W(CW), .DEPTH(TAPS), .AW(AW)) u_coef (
    .clk(clk), .we(coef_we), .waddr(coef_addr), .wdata(coef_data),
    .re(rd_en), .raddr(tap_addr), .rdata(coef_rd)
  );

  for (genvar p = 0; p < 2; p++) begin : g_path
    logic [DW-1:0] hist_rd;
    logic          path_en;
    assign path_en = (p == 0) ? 1'b1 : q_en;

    dfir_ram #(.W(DW), .DEPTH(TAPS), .AW(AW)) u_hist (
      .clk(clk), .we(in_valid), .waddr(wr_addr), .wdata((p == 0) ? in_i : in_q),
      .re(rd_en), .raddr(rd_addr), .rdata(hist_rd)
    );

    dfir_mac #(.DW(DW), .CW(CW), .OW(OW), .GW(GW)) u_mac (
      .clk(clk), .rst(rst), .en_path(path_en), .acc_en(acc_en),
      .acc_first(acc_first), .acc_last(acc_last), .acc_keep(acc_keep),
      .sample(hist_rd), .coef(coef_rd),
      .out_data(path_out[p]), .out_valid(path_vld[p])
    );
  end

  assign out_i       = path_out[0];
  assign out_i_valid = path_vld[0];
  assign out_q       = path_out[1];
  assign out_q_valid = path_vld[1];

  AST_IQ_TOGETHER: assert property (@(posedge clk) disable iff (rst)
    (mode_e == MODE_QUAD) |-> (out_i_valid == out_q_valid)); // R3
  AST_Q_SILENT: assert property (@(posedge clk) disable iff (rst)
    (mode_e != MODE_QUAD) |-> (!out_q_valid && out_q == '0)); // R4, R5
endmodule

// File: tb/deci_fir_bench.sv
module deci_fir_bench;
  localparam int DW = 16, CW = 22, OW = 38, TAPS = 6;
  localparam int AW = $clog2(TAPS);
  localparam longint SMAX = (64'sd1 <<< (OW-1)) - 1;
  localparam longint SMIN = -(64'sd1 <<< (OW-1));

  logic clk = 1'b0, rst = 1'b1;
  logic [1:0] mode = 2'd0;
  logic coef_we = 1'b0;
  logic [AW-1:0] coef_addr = '0;
  logic [CW-1:0] coef_data = '0;
  logic in_valid = 1'b0;
  logic [DW-1:0] in_i = '0, in_q = '0;
  logic [OW-1:0] out_i, out_q;
  logic out_i_valid, out_q_valid;

  deci_fir #(.DW(DW), .CW(CW), .OW(OW), .TAPS(TAPS)) u_deci_fir (
    .clk(clk), .rst(rst), .mode(mode), .coef_we(coef_we), .coef_addr(coef_addr),
    .coef_data(coef_data), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .out_i(out_i), .out_i_valid(out_i_valid), .out_q(out_q), .out_q_valid(out_q_valid)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  longint cf [TAPS];
  longint hi [$], hq [$];
  int n_in = 0;
  longint qi [$], qq [$];
  int qi_c [$], qq_c [$];
  string qi_t [$], qq_t [$];

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint sat(input longint v);
    if (v > SMAX) return SMAX;
    if (v < SMIN) return SMIN;
    return v;
  endfunction

  function automatic longint fir(ref longint h [$]);
    longint s = 0;
    for (int k = 0; k < h.size(); k++) s += cf[k] * h[k];
    return sat(s);
  endfunction

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (out_i_valid) begin
        if (qi.size() == 0) check(0, "R2 unexpected I result", longint'($signed(out_i)), 0);
        else begin
          check(longint'($signed(out_i)) == qi[0], qi_t[0], longint'($signed(out_i)), qi[0]);
          check(cyc == qi_c[0], "R8 I latency", cyc, qi_c[0]);
          void'(qi.pop_front()); void'(qi_c.pop_front()); void'(qi_t.pop_front());
        end
      end
      if (out_q_valid) begin
        if (qq.size() == 0) check(0, "R4/R5 unexpected Q result", longint'($signed(out_q)), 0);
        else begin
          check(longint'($signed(out_q)) == qq[0], qq_t[0], longint'($signed(out_q)), qq[0]);
          check(cyc == qq_c[0], "R8 Q latency", cyc, qq_c[0]);
          void'(qq.pop_front()); void'(qq_c.pop_front()); void'(qq_t.pop_front());
        end
      end
      if (mode != 2'd0 && out_q != '0) check(0, "R4/R5 Q not zero", longint'($signed(out_q)), 0);
    end
  end

  task automatic do_reset(input logic [1:0] m);
    @(negedge clk);
    rst = 1'b1; mode = m;
    hi.delete(); hq.delete(); n_in = 0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic load(input int k, input longint v);
    @(negedge clk);
    coef_we = 1'b1; coef_addr = AW'(k); coef_data = CW'(v); cf[k] = v;
    @(negedge clk);
    coef_we = 1'b0;
  endtask

  task automatic send(input longint xi, input longint xq, input string tag);
    int dec;
    @(negedge clk);
    in_valid = 1'b1; in_i = DW'(xi); in_q = DW'(xq);
    hi.push_front(xi); hq.push_front(xq);
    if (hi.size() > TAPS) begin void'(hi.pop_back()); void'(hq.pop_back()); end
    n_in++;
    dec = (mode == 2'd1) ? 2 : 4;
    if (n_in % dec == 0) begin
      qi.push_back(fir(hi)); qi_c.push_back(cyc + 1 + TAPS + 1); qi_t.push_back(tag);
      if (mode == 2'd0) begin
        qq.push_back(fir(hq)); qq_c.push_back(cyc + 1 + TAPS + 1); qq_t.push_back(tag);
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (TAPS + 3) @(negedge clk);
  endtask

  task automatic drain(input string tag);
    repeat (TAPS + 4) @(negedge clk);
    check(qi.size() == 0 && qq.size() == 0, tag, qi.size() + qq.size(), 0);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int k = 0; k < TAPS; k++) cf[k] = 0;
    do_reset(2'd0);
    // R7: reset state
    check(out_i == '0, "R7 out_i after reset", longint'($signed(out_i)), 0);
    check(out_q == '0, "R7 out_q after reset", longint'($signed(out_q)), 0);
    check(!out_i_valid && !out_q_valid, "R7 strobes after reset", out_i_valid + out_q_valid, 0);

    // R1: distinct taps, loaded while idle
    for (int k = 0; k < TAPS; k++) load(k, (k + 1) * 1000 - ((k % 2) ? 7000 : 0));

    // R3/R2: quadrature, varied samples
    for (int j = 0; j < 16; j++)
      send(((j * 7919) % 20000) - 10000, 9000 - ((j * 4241) % 18000), "R3 quadrature result");
    drain("R3 all quadrature results seen");

    // R1: impulse reveals tap order, filter-only mode 2
    do_reset(2'd2);
    send(1000, 55, "R1 impulse tap order");
    for (int j = 0; j < 11; j++) send(0, 0, "R1 impulse tap order");
    drain("R5 filter-only mode 2 count");

    // R4: real mode, decimate by 2
    do_reset(2'd1);
    for (int j = 0; j < 12; j++)
      send(((j * 3001) % 30000) - 15000, 123, "R4 real result");
    drain("R4 real results count, no Q");

    // R5: mode 3 behaves as filter-only
    do_reset(2'd3);
    for (int j = 0; j < 8; j++) send(-2000 + j * 611, 777, "R5 filter-only mode 3");
    drain("R5 filter-only mode 3 count, no Q");

    // R7: reset part-way through a slot restarts phase and clears history
    do_reset(2'd0);
    send(30000, -30000, "R7 pre-reset");
    send(29000, -29000, "R7 pre-reset");
    do_reset(2'd0);
    for (int j = 0; j < 4; j++) send(100 * (j + 1), -50 * (j + 1), "R7 history cleared");
    drain("R7 phase restarted");

    // R6: saturation at both limits
    for (int k = 0; k < TAPS; k++) load(k, (64'sd1 <<< (CW-1)) - 1);
    do_reset(2'd0);
    for (int j = 0; j < 4; j++) send(32767, -32768, "R6 saturation");
    drain("R6 saturation results seen");
    check(cf[0] * 32767 * 4 > SMAX, "R6 stimulus exceeds range", cf[0] * 32767 * 4, SMAX);

    finish_run();
  end
endmodule